// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. On a clock edge where the clock enable is high and the advance/load input is low, a selected access captures a full starting address. On later enabled edges with advance/load high, the two least significant address bits step to the next burst position, while every bit above them keeps the value taken at the load. A mode input picks one of two burst orders. In linear order the low bits count up and wrap modulo four. In interleaved order the low bits are the starting bits XOR a beat count.

The order is taken from the mode input at the load and held until the next load, so a change on that pin in the middle of a burst has no effect. A load edge with the select qualifier low deselects the sequencer. The address stays where it was, and advance requests are ignored until a selected load arrives. When the clock enable is low the whole sequence is frozen.

Top module: `burst_seq`

## Requirements
- R1: After reset, curAddr is all zeros and the burst order is interleaved.
- R2: On an edge with clkEn=1, advLoad=0 and selIn=1, curAddr takes startAddr from the cycle after that edge.
- R3: With burstMode=0 latched at the load, the low two bits after n advances equal (start + n) mod 4.
- R4: With burstMode=1 latched at the load, the low two bits after n advances equal start XOR (n mod 4), for example 1,0,3,2 from a start of 1.
- R5: burstMode is sampled only on a selected load; 1 means interleaved and 0 means linear. Changing it between loads does not alter the order.
- R6: The address bits above the low two never change between loads.
- R7: Advances past the fourth beat keep wrapping in the same order until the next load.
- R8: While clkEn=0, curAddr does not change, whatever the other inputs do.
- R9: An edge with clkEn=1, advLoad=0 and selIn=0 leaves curAddr unchanged. Advances that follow it are ignored until the next selected load.
- R10: Every selected load restarts the beat count at zero, including a load in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable, active high; low freezes the sequence |
| advLoad | input | 1 | 0 = load (or deselect), 1 = advance one beat |
| burstMode | input | 1 | 1 = interleaved order, 0 = linear order |
| selIn | input | 1 | Select qualifier for a load |
| startAddr | input | ADDR_W | Full starting address |
| curAddr | output | ADDR_W | Current burst address |

## Verification
Every start offset from 0 to 3 is combined with both orders and several upper-address values, and each burst runs for six advances. This separates the wrap-around sum of linear order from the XOR of interleaved order, and it shows whether wrapping continues past the fourth beat. Other runs put clock-enable gaps in the middle of bursts, toggle the mode pin in the middle of a burst, reload in the middle of a burst, and deselect before advancing. These runs separate freezing, the latching of the mode at the load, the restart of the beat count, and the blocking of advances.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic advance;
    logic deselect;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkEn,
  input  logic        advLoad,
  input  logic        selIn,
  output seqStrobes_t strobes
);
  logic active;

  always_comb begin
    strobes.load     = clkEn & ~advLoad & selIn;
    strobes.deselect = clkEn & ~advLoad & ~selIn;
    strobes.advance  = clkEn & advLoad & active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 active <= 1'b0;
    else if (strobes.load)     active <= 1'b1;
    else if (strobes.deselect) active <= 1'b0;
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.advance, strobes.deselect}));

  assert_no_adv_after_desel_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.deselect |=> !strobes.advance);
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int LW = $clog2(BEATS);
  localparam int UW = ADDR_W - LW;

  logic [UW-1:0] upperReg;
  logic [LW-1:0] startLow;
  logic [LW-1:0] beatCnt;
  logic          modeReg;
  logic [LW-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperReg <= '0;
      startLow <= '0;
      beatCnt  <= '0;
      modeReg  <= 1'b1;
    end else if (strobes.load) begin
      upperReg <= startAddr[ADDR_W-1:LW];
      startLow <= startAddr[LW-1:0];
      beatCnt  <= '0;
      modeReg  <= burstMode;
    end else if (strobes.advance) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (modeReg) lowBits = startLow ^ beatCnt;
    else         lowBits = startLow + beatCnt;
  end

  assign curAddr = {upperReg, lowBits};

  assert_upper_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(curAddr[ADDR_W-1:LW]));

  assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (curAddr[LW-1:0] == $past(startAddr[LW-1:0])));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !modeReg) |=> (curAddr[LW-1:0] == $past(curAddr[LW-1:0]) + 1'b1));

  assert_inter_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && modeReg) |=>
      ((curAddr[LW-1:0] ^ $past(curAddr[LW-1:0])) == ($past(beatCnt) ^ ($past(beatCnt) + 1'b1))));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advLoad,
  input  logic              burstMode,
  input  logic              selIn,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] curAddr
);
  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advLoad(advLoad),
    .selIn(selIn), .strobes(strobes)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .burstMode(burstMode),
    .startAddr(startAddr), .curAddr(curAddr)
  );

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(curAddr));
endmodule

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb;
  localparam int AW = 8;

  logic clk = 0, rstN = 0, clkEn = 0, advLoad = 0, burstMode = 0, selIn = 0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] curAddr;
  int total = 0, bad = 0;
  bit done = 0;

  logic [AW-1:0] mStart = '0;
  int mCnt = 0;
  bit mMode = 1, mAct = 0;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .BEATS(4)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advLoad(advLoad), .burstMode(burstMode),
    .selIn(selIn), .startAddr(startAddr), .curAddr(curAddr)
  );

  function automatic logic [AW-1:0] expAddr();
    logic [1:0] lo, c;
    c = 2'(mCnt);
    lo = mMode ? (mStart[1:0] ^ c) : (mStart[1:0] + c);
    return {mStart[AW-1:2], lo};
  endfunction

  task automatic check(string req);
    total++;
    if (curAddr !== expAddr()) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, curAddr, expAddr());
    end
  endtask

  task automatic cyc(bit ce, bit al, bit md, bit sel, logic [AW-1:0] a, string req);
    clkEn = ce; advLoad = al; burstMode = md; selIn = sel; startAddr = a;
    @(posedge clk);
    #1;
    if (ce) begin
      if (!al) begin
        if (sel) begin mStart = a; mCnt = 0; mMode = md; mAct = 1; end
        else mAct = 0;
      end else if (mAct) mCnt++;
    end
    check(req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    rstN = 1;
    #1;
    // R3 R4 R6 R7: sweep both orders, every start offset, several upper values
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int u = 0; u < 4; u++) begin
          logic [AW-1:0] a;
          a = {6'(u * 13 + 5), 2'(s)};
          cyc(1, 0, m[0], 1, a, "R2 load");
          for (int k = 0; k < 6; k++)
            cyc(1, 1, m[0], 1, ~a, m[0] ? "R4 R7 interleaved step" : "R3 R7 linear step");
        end
    // R8: freeze with clkEn low
    cyc(1, 0, 0, 1, 8'h42, "R2 load");
    cyc(1, 1, 0, 1, 8'h00, "R3 step");
    for (int k = 0; k < 3; k++) cyc(0, k[0], 1, 1, 8'hFF, "R8 freeze");
    cyc(1, 1, 0, 1, 8'h00, "R3 step after freeze");
    // R5: mode change mid-burst ignored
    cyc(1, 0, 1, 1, 8'h91, "R5 load interleaved");
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 1, 8'h00, "R5 mode held");
    // R10: reload mid-burst restarts count
    cyc(1, 0, 0, 1, 8'h3A, "R2 load");
    cyc(1, 1, 0, 1, 8'h00, "R3 step");
    cyc(1, 0, 0, 1, 8'h3A, "R10 reload");
    cyc(1, 1, 0, 1, 8'h00, "R10 step from zero");
    // R9: deselect holds and blocks advances
    cyc(1, 0, 1, 0, 8'hEE, "R9 deselect");
    for (int k = 0; k < 3; k++) cyc(1, 1, 0, 1, 8'h00, "R9 advance ignored");
    cyc(1, 0, 1, 1, 8'h57, "R9 reload");
    cyc(1, 1, 1, 1, 8'h00, "R4 step");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule